// File: doc/BRIEF.md
# Microcoded Bus Pattern Sequencer

The sequencer drives an external memory bus from a table of 64 control words that software fills through a plain write port, instead of from a fixed state machine. Each word holds a group of control strobes for one bus clock, a transfer-acknowledge bit and an end-of-pattern bit. When a request arrives while the sequencer is idle, it resolves to a hardwired start word. From there the sequencer executes one word per clock until it reaches a word whose end bit is set. The request can be a memory read or write, single-beat or burst, a refresh tick, an exception, or a software run command aimed at any word.

For memory accesses the sequencer counts the acknowledges a pattern produces and compares the total with the number the transfer needs. A single beat needs exactly one. A 32-byte burst needs 32, 16 or 8 acknowledges for an 8-, 16- or 32-bit port. A mismatch raises a sticky flag and does not stall the bus. A table write that arrives while a pattern is running is dropped and raises its own sticky flag.

Top module: `uprog_seq`

## Requirements
- R1: A table write (`pat_we_i`) accepted while idle stores `pat_data_i` at `pat_addr_i` (0..63). Word layout: bits [3:0] are strobes, bit 4 is transfer acknowledge, bit 5 is end-of-pattern.
- R2: Memory requests start at word 0x00 for a single read, 0x08 for a burst read, 0x18 for a single write and 0x20 for a burst write. `mem_wr_i`=1 selects write and `mem_burst_i`=1 selects burst.
- R3: A refresh request starts at word 0x30. An exception request starts at word 0x3C.
- R4: A run command (`run_i`=1 with `run_op_i`=2'b11) starts at `run_addr_i`. A run with any other `run_op_i` value starts nothing.
- R5: When requests arrive together in an idle cycle, the exception wins, then refresh, then the run command, then the memory request. Exactly one request is accepted.
- R6: A request accepted at a clock edge makes its start word drive `strobe_o` and `ta_o` in the following cycle. Each later cycle executes the next word, and the address wraps from 63 to 0.
- R7: The word with the end bit set is the last one executed, and `last_o` is high during it. `busy_o` falls in the next cycle, which is always idle before another request is accepted.
- R8: At the end of a memory pattern, `cnt_err_o` is set if the number of acknowledges differs from the expected count. The expected count is 1 for a single beat. For a burst it depends on `port_w_i`: 32 for 2'b00 (8-bit), 16 for 2'b01 (16-bit) and 8 for 2'b10 or 2'b11 (32-bit). The flag stays set until reset and does not alter execution. Refresh, exception and run patterns are not counted.
- R9: A table write issued while `busy_o` is high leaves the table unchanged and sets `wr_err_o`, which stays set until reset.
- R10: After reset, and in every idle cycle, `busy_o`, `strobe_o`, `ta_o` and `last_o` are 0. Both error flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pat_we_i | input | 1 | Table write strobe |
| pat_addr_i | input | 6 | Table write address |
| pat_data_i | input | 6 | Table write data |
| req_exc_i | input | 1 | Exception request |
| req_ref_i | input | 1 | Refresh request |
| run_i | input | 1 | Software command valid |
| run_op_i | input | 2 | Command operation, 2'b11 = run |
| run_addr_i | input | 6 | Start word for a run command |
| mem_req_i | input | 1 | Memory access request |
| mem_wr_i | input | 1 | Memory access is a write |
| mem_burst_i | input | 1 | Memory access is a burst |
| port_w_i | input | 2 | Port width: 00 = 8, 01 = 16, 1x = 32 bits |
| busy_o | output | 1 | Pattern executing |
| strobe_o | output | 4 | Control strobes of the current word |
| ta_o | output | 1 | Transfer acknowledge of the current word |
| last_o | output | 1 | Current word ends the pattern |
| cnt_err_o | output | 1 | Sticky acknowledge-count mismatch |
| wr_err_o | output | 1 | Sticky rejected table write |

## Verification
Table writes and pattern execution share one clock and can coincide in two ways that must resolve differently. In the first, the bench issues a write in the same idle cycle that a request is accepted, aimed at that request's start word. The write must take effect, so the first executed word must show the new data. In the second, the bench issues a write during a running pattern, including the cycle of its end word. The write must be rejected, which is judged by `wr_err_o` and by running the pattern again and comparing every strobe with the unchanged table.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int AW    = 6;
  localparam int CNT_W = 8;

  localparam logic [AW-1:0] A_RD_S = 6'h00;
  localparam logic [AW-1:0] A_RD_B = 6'h08;
  localparam logic [AW-1:0] A_WR_S = 6'h18;
  localparam logic [AW-1:0] A_WR_B = 6'h20;
  localparam logic [AW-1:0] A_REF  = 6'h30;
  localparam logic [AW-1:0] A_EXC  = 6'h3C;

  localparam logic [1:0] OP_RUN = 2'b11;

  typedef enum logic [2:0] {
    K_RD_S, K_RD_B, K_WR_S, K_WR_B, K_REF, K_EXC, K_RUN
  } kind_e;

  function automatic logic [CNT_W-1:0] acks_expected(kind_e k, logic [1:0] pw);
    logic [CNT_W-1:0] n;
    n = '0;
    if (k == K_RD_S || k == K_WR_S) n = CNT_W'(1);
    else if (k == K_RD_B || k == K_WR_B) begin
      case (pw)
        2'b00:   n = CNT_W'(32);
        2'b01:   n = CNT_W'(16);
        default: n = CNT_W'(8);
      endcase
    end
    return n;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  p_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/useq_pick.sv
module useq_pick
  import useq_pkg::*;
(
  input  logic          exc_i,
  input  logic          ref_i,
  input  logic          run_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] run_addr_i,
  input  logic          mem_i,
  input  logic          mem_wr_i,
  input  logic          mem_burst_i,
  output logic          valid_o,
  output logic [3:0]    grant_o,
  output logic [AW-1:0] start_o,
  output kind_e         kind_o
);
  logic [3:0] req_v;

  // bit 0 has the highest priority
  assign req_v   = {mem_i, run_i && (op_i == OP_RUN), ref_i, exc_i};
  assign grant_o = req_v & (~req_v + 4'd1);
  assign valid_o = |req_v;

  always_comb begin
    start_o = A_RD_S;
    kind_o  = K_RD_S;
    if (grant_o[0]) begin
      start_o = A_EXC;
      kind_o  = K_EXC;
    end else if (grant_o[1]) begin
      start_o = A_REF;
      kind_o  = K_REF;
    end else if (grant_o[2]) begin
      start_o = run_addr_i;
      kind_o  = K_RUN;
    end else begin
      case ({mem_wr_i, mem_burst_i})
        2'b00: begin start_o = A_RD_S; kind_o = K_RD_S; end
        2'b01: begin start_o = A_RD_B; kind_o = K_RD_B; end
        2'b10: begin start_o = A_WR_S; kind_o = K_WR_S; end
        default: begin start_o = A_WR_B; kind_o = K_WR_B; end
      endcase
    end
  end
endmodule

// File: rtl/useq_ackchk.sv
module useq_ackchk #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          check_i,
  input  logic [CW-1:0] exp_i,
  input  logic          ack_i,
  input  logic          end_i,
  output logic          err_o
);
  logic [CW-1:0] cnt_q, exp_q, cnt_nx;
  logic          chk_q;

  assign cnt_nx = (&cnt_q) ? cnt_q : cnt_q + CW'(ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= '0;
      chk_q <= 1'b0;
      err_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      exp_q <= exp_i;
      chk_q <= check_i;
    end else begin
      cnt_q <= cnt_nx;
      if (end_i && chk_q && (cnt_nx != exp_q)) err_o <= 1'b1;
    end
  end

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/uprog_seq.sv
module uprog_seq
  import useq_pkg::*;
#(
  parameter int CTRL_W = 4,
  localparam int W     = CTRL_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pat_we_i,
  input  logic [AW-1:0]     pat_addr_i,
  input  logic [W-1:0]      pat_data_i,
  input  logic              req_exc_i,
  input  logic              req_ref_i,
  input  logic              run_i,
  input  logic [1:0]        run_op_i,
  input  logic [AW-1:0]     run_addr_i,
  input  logic              mem_req_i,
  input  logic              mem_wr_i,
  input  logic              mem_burst_i,
  input  logic [1:0]        port_w_i,
  output logic              busy_o,
  output logic [CTRL_W-1:0] strobe_o,
  output logic              ta_o,
  output logic              last_o,
  output logic              cnt_err_o,
  output logic              wr_err_o
);
  logic          busy_q, wr_err_q;
  logic [AW-1:0] pc_q;
  logic [W-1:0]  cur_w;
  logic          pk_valid, accept, wr_ok;
  logic [3:0]    pk_grant;
  logic [AW-1:0] pk_start;
  kind_e         pk_kind;

  assign wr_ok  = pat_we_i && !busy_q;
  assign accept = pk_valid && !busy_q;

  useq_store #(.DEPTH(1 << AW), .DW(W)) u_store (
    .clk_i, .rst_ni,
    .we_i(wr_ok), .waddr_i(pat_addr_i), .wdata_i(pat_data_i),
    .raddr_i(pc_q), .rdata_o(cur_w)
  );

  useq_pick u_pick (
    .exc_i(req_exc_i), .ref_i(req_ref_i), .run_i, .op_i(run_op_i),
    .run_addr_i, .mem_i(mem_req_i), .mem_wr_i, .mem_burst_i,
    .valid_o(pk_valid), .grant_o(pk_grant), .start_o(pk_start), .kind_o(pk_kind)
  );

  useq_ackchk #(.CW(CNT_W)) u_ackchk (
    .clk_i, .rst_ni,
    .start_i(accept), .check_i(pk_kind <= K_WR_B),
    .exp_i(acks_expected(pk_kind, port_w_i)),
    .ack_i(ta_o), .end_i(last_o), .err_o(cnt_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      pc_q     <= '0;
      wr_err_q <= 1'b0;
    end else begin
      if (pat_we_i && busy_q) wr_err_q <= 1'b1;
      if (accept) begin
        busy_q <= 1'b1;
        pc_q   <= pk_start;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        pc_q   <= pc_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign strobe_o = busy_q ? cur_w[CTRL_W-1:0] : '0;
  assign ta_o     = busy_q && cur_w[CTRL_W];
  assign last_o   = busy_q && cur_w[CTRL_W+1];
  assign wr_err_o = wr_err_q;

  p_one_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pk_grant));
  p_exc_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_exc_i) |=> (busy_o && pc_q == A_EXC));
  p_end_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o);
  p_quiet_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (strobe_o == '0 && !ta_o && !last_o));
  p_wr_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_we_i && busy_o) |=> wr_err_o);
  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> (busy_o && pc_q == $past(pc_q) + 1'b1));
endmodule

// File: tb/uprog_seq_bench.sv
module uprog_seq_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pat_we = 0, req_exc = 0, req_ref = 0, run = 0;
  logic       mem_req = 0, mem_wr = 0, mem_burst = 0;
  logic [5:0] pat_addr = 0, pat_data = 0, run_addr = 0;
  logic [1:0] run_op = 0, port_w = 0;
  logic       busy, ta, last, cnt_err, wr_err;
  logic [3:0] strobe;

  logic [5:0] model [64];
  int  n_chk = 0, n_fail = 0;
  bit  exp_cnt_err = 0, exp_wr_err = 0;

  always #10 clk = ~clk;

  uprog_seq u_uprog_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .pat_we_i(pat_we), .pat_addr_i(pat_addr), .pat_data_i(pat_data),
    .req_exc_i(req_exc), .req_ref_i(req_ref), .run_i(run), .run_op_i(run_op),
    .run_addr_i(run_addr), .mem_req_i(mem_req), .mem_wr_i(mem_wr),
    .mem_burst_i(mem_burst), .port_w_i(port_w),
    .busy_o(busy), .strobe_o(strobe), .ta_o(ta), .last_o(last),
    .cnt_err_o(cnt_err), .wr_err_o(wr_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // rq = {exc, ref, run, mem}; priority exc > ref > run(op 11) > mem
  function automatic bit req_valid(logic [3:0] rq, logic [1:0] op);
    return rq[3] || rq[2] || (rq[1] && op == 2'b11) || rq[0];
  endfunction

  function automatic logic [5:0] exp_start(logic [3:0] rq, logic [1:0] op, logic [5:0] ra,
                                            logic wr, logic bu);
    if (rq[3]) return 6'h3C;
    if (rq[2]) return 6'h30;
    if (rq[1] && op == 2'b11) return ra;
    case ({wr, bu})
      2'b00: return 6'h00;
      2'b01: return 6'h08;
      2'b10: return 6'h18;
      default: return 6'h20;
    endcase
  endfunction

  // 0 = not counted
  function automatic int exp_acks(logic [3:0] rq, logic [1:0] op, logic bu, logic [1:0] w);
    if (rq[3] || rq[2] || (rq[1] && op == 2'b11)) return 0;
    if (!bu) return 1;
    return (w == 2'b00) ? 32 : (w == 2'b01) ? 16 : 8;
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 64; i++) model[i] = '0;
    exp_cnt_err = 0;
    exp_wr_err = 0;
    @(negedge clk);
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [5:0] d);
    pat_we = 1; pat_addr = a; pat_data = d;
    model[a] = d;
    @(negedge clk);
    pat_we = 0;
  endtask

  task automatic exec_check(input logic [3:0] rq, input logic wr, input logic bu,
                            input logic [1:0] op, input logic [5:0] ra, input logic [1:0] w,
                            input bit pre_we, input logic [5:0] pre_a, input logic [5:0] pre_d,
                            input int poke_at, input string tag);
    logic [5:0] pc;
    int acks, need;
    bit done;
    req_exc = rq[3]; req_ref = rq[2]; run = rq[1]; mem_req = rq[0];
    run_op = op; run_addr = ra; mem_wr = wr; mem_burst = bu; port_w = w;
    if (pre_we) begin
      pat_we = 1; pat_addr = pre_a; pat_data = pre_d; model[pre_a] = pre_d;
    end
    @(negedge clk);
    req_exc = 0; req_ref = 0; run = 0; mem_req = 0; pat_we = 0;
    pc = exp_start(rq, op, ra, wr, bu);
    acks = 0;
    done = 0;
    for (int n = 0; n < 70 && !done; n++) begin
      check(busy == 1'b1, {tag, " busy while running"}, busy, 1);
      check(strobe == model[pc][3:0], {tag, " R6 strobes"}, strobe, model[pc][3:0]);
      check(ta == model[pc][4], {tag, " R6 ack"}, ta, model[pc][4]);
      check(last == model[pc][5], {tag, " R7 last flag"}, last, model[pc][5]);
      if (n == poke_at) begin
        pat_we = 1; pat_addr = pc; pat_data = ~model[pc];
        exp_wr_err = 1;
      end
      acks += model[pc][4];
      if (model[pc][5]) done = 1;
      else pc = pc + 1;
      @(negedge clk);
      pat_we = 0;
    end
    check(done, {tag, " R7 pattern ended"}, done, 1);
    check(busy == 1'b0, {tag, " R7 idle after last"}, busy, 0);
    need = exp_acks(rq, op, bu, w);
    if (need != 0 && acks != need) exp_cnt_err = 1;
    check(cnt_err == exp_cnt_err, {tag, " R8 count flag"}, cnt_err, exp_cnt_err);
    check(wr_err == exp_wr_err, {tag, " R9 write flag"}, wr_err, exp_wr_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R10 reset state
    check(busy == 0 && strobe == 0 && ta == 0 && last == 0, "R10 idle outputs", busy, 0);
    check(cnt_err == 0 && wr_err == 0, "R10 flags clear", cnt_err + wr_err, 0);

    // R4 a command other than run starts nothing
    run = 1; run_op = 2'b01; run_addr = 6'h05;
    @(negedge clk);
    run = 0;
    check(busy == 0, "R4 non-run op ignored", busy, 0);
    check(strobe == 0, "R4 no strobes", strobe, 0);

    // R1 R3 R5 start words, all single-word patterns
    wr_word(6'h3C, 6'b10_0001);
    wr_word(6'h30, 6'b10_0010);
    wr_word(6'h11, 6'b10_0111);
    wr_word(6'h00, 6'b11_0011);
    wr_word(6'h18, 6'b11_0101);
    exec_check(4'b1111, 0, 0, 2'b11, 6'h11, 2, 0, 0, 0, -1, "R5 R3 exception wins");
    exec_check(4'b0111, 0, 0, 2'b11, 6'h11, 2, 0, 0, 0, -1, "R5 R3 refresh next");
    exec_check(4'b0011, 0, 0, 2'b11, 6'h11, 2, 0, 0, 0, -1, "R5 R4 run over memory");
    exec_check(4'b0011, 0, 0, 2'b10, 6'h11, 2, 0, 0, 0, -1, "R5 R2 bad op gives memory");
    exec_check(4'b0001, 1, 0, 2'b00, 6'h00, 2, 0, 0, 0, -1, "R2 write single");

    // R8 bursts
    for (int i = 8; i < 16; i++) wr_word(6'(i), (i == 15) ? 6'b11_1000 : 6'b01_1000);
    exec_check(4'b0001, 0, 1, 0, 0, 2'b10, 0, 0, 0, -1, "R2 R8 read burst 32-bit");
    for (int i = 32; i < 64; i++) wr_word(6'(i), (i == 63) ? 6'b11_0100 : 6'b01_0100);
    exec_check(4'b0001, 1, 1, 0, 0, 2'b00, 0, 0, 0, -1, "R2 R8 write burst 8-bit");
    exec_check(4'b0001, 1, 1, 0, 0, 2'b01, 0, 0, 0, -1, "R8 mismatch 16-bit");
    exec_check(4'b0001, 0, 1, 0, 0, 2'b11, 0, 0, 0, -1, "R8 flag sticks");

    // R9 writes during a run
    do_reset();
    wr_word(6'h18, 6'b00_0001);
    wr_word(6'h19, 6'b01_0010);
    wr_word(6'h1A, 6'b10_0100);
    exec_check(4'b0001, 1, 0, 0, 0, 2, 0, 0, 0, 1, "R9 write mid pattern");
    exec_check(4'b0001, 1, 0, 0, 0, 2, 0, 0, 0, 2, "R9 write on last word");
    exec_check(4'b0001, 1, 0, 0, 0, 2, 0, 0, 0, -1, "R9 table unchanged");
    // R1 write in the accept cycle is taken and seen
    exec_check(4'b0001, 1, 0, 0, 0, 2, 1, 6'h18, 6'b11_1111, -1, "R1 write with request");

    // random patterns
    do_reset();
    for (int it = 0; it < 40; it++) begin
      logic [3:0] rq;
      logic [1:0] op;
      if (it % 8 == 0) begin
        for (int a = 0; a < 64; a++) begin
          logic [5:0] d;
          d = 6'($urandom);
          d[5] = (a == 63) || ($urandom % 3 == 0);
          wr_word(6'(a), d);
        end
      end
      rq = 4'($urandom);
      op = ($urandom % 2) ? 2'b11 : 2'($urandom);
      if (!req_valid(rq, op)) rq[0] = 1;
      exec_check(rq, 1'($urandom), 1'($urandom), op, 6'($urandom), 2'($urandom),
                 0, 0, 0, -1, "R5 R6 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule